// File: doc/BRIEF.md
# Power Rail Sequencing Controller

This block turns on four supply rails of a board, one at a time, in a fixed order: the core rail, then the 1.0 V rail, then the 1.8 V rail, then the 1.5 V rail. It has one enable output for each rail. It watches a power-good input for each rail that has one. A rising edge on the start input begins the sequence. Each enable waits until the previous rail has reported good and a programmable hold-off has expired. All power-good inputs and the start input pass through two-flop synchronisers before the state machine sees them.

The 1.8 V rail has no power-good feedback. The block produces that rail's good flag itself, from a hold-off counted from its own enable. That flag gates the next rail. After the 1.8 V rail has stayed good for one more hold-off, the block emits a single-cycle strobe that starts the external clock generator's initialisation. A final all-good output rises once the last rail is good and settled.

A rail that fails to report good within a timeout sends the block to a fault shutdown. So does a power-good that drops after its rail was accepted. The shutdown releases the enables in reverse order, one per cycle, and holds a fault flag until reset. At 25 MHz the default hold-off is 125000 cycles (5 ms) and the default timeout is 500000 cycles (20 ms).

Top module: `rail_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output is low: all four enables, the 1.8 V good flag, the clock start strobe, all-good and the fault flag. Reset also clears a latched fault.
- R2: Without a rising edge on the start input, the core enable stays low. A rising edge on the start input raises the core enable.
- R3: The enables rise only in the order core, 1.0 V, 1.8 V, 1.5 V, and none rises while an earlier one is low. The 1.0 V enable rises exactly HOLD_CYCLES+3 cycles after the core power-good input goes high. The 1.8 V enable rises exactly HOLD_CYCLES+3 cycles after the 1.0 V power-good input goes high. Neither rises before its power-good input.
- R4: The 1.8 V good output rises exactly HOLD_CYCLES cycles after the 1.8 V enable rises, and it is never high while that enable is low.
- R5: The clock start strobe is high for exactly one cycle, HOLD_CYCLES cycles after the 1.8 V good output rises, in the same cycle that the 1.5 V enable rises. It occurs once per power-up, and a new start edge after completion does not repeat it.
- R6: All-good rises exactly HOLD_CYCLES+3 cycles after the 1.5 V power-good input goes high.
- R7: If a rail's power-good input stays low for TIMEOUT_CYCLES after that rail is enabled, the fault flag rises, and all enables are low within a few cycles.
- R8: If a power-good input falls after its rail was accepted, the fault flag rises and all-good falls.
- R9: The fault shutdown releases the enables at most one per cycle, in the order 1.5 V, 1.8 V (together with its good flag), 1.0 V, core. The fault flag then stays high, and start edges are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Sequence request, acted on at its rising edge |
| pgCoreIn | input | 1 | Core rail power-good, asynchronous |
| pg1v0In | input | 1 | 1.0 V rail power-good, asynchronous |
| pg1v5In | input | 1 | 1.5 V rail power-good, asynchronous |
| enCore | output | 1 | Core rail enable |
| en1v0 | output | 1 | 1.0 V rail enable |
| en1v8 | output | 1 | 1.8 V rail enable |
| en1v5 | output | 1 | 1.5 V rail enable |
| pg1v8Out | output | 1 | Timer-derived 1.8 V power-good |
| clkInitPulse | output | 1 | One-cycle clock generator start strobe |
| allGood | output | 1 | All rails up and settled |
| faultFlag | output | 1 | Sequencing fault latched |

## Verification
If the state machine sits in the wrong step, an enable rises at the wrong time or out of order. It shows on the enable pins as a shift of whole cycles from the HOLD_CYCLES+3 distance to the matching power-good edge. A miscounting timer moves the 1.8 V good flag and the clock strobe away from their exact HOLD_CYCLES spacing on the first power-up. A broken shutdown path shows within four cycles of the fault flag, as enables that drop together or in the wrong order.

// File: rtl/rail_seq_pkg.sv
`timescale 1ns/1ps
package rail_seq_pkg;

  // Rail index inside every four-bit enable vector; order is the power-up order.
  localparam int RAIL_CORE = 0;
  localparam int RAIL_V10  = 1;
  localparam int RAIL_V18  = 2;
  localparam int RAIL_V15  = 3;
  localparam int RAIL_COUNT = 4;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CORE_WAIT,
    S_CORE_HOLD,
    S_V10_WAIT,
    S_V10_HOLD,
    S_V18_RAMP,
    S_V18_STABLE,
    S_V15_WAIT,
    S_V15_HOLD,
    S_DONE,
    S_OFF15,
    S_OFF18,
    S_OFF10,
    S_OFFCORE,
    S_HALT
  } seqState_t;

  // Strobes from control to datapath, registered by the datapath.
  typedef struct packed {
    logic                  clrTimer;
    logic                  shutdown;
    logic [RAIL_COUNT-1:0] enTarget;
    logic                  pg18;
    logic                  clkPulse;
    logic                  allGood;
    logic                  fault;
  } seqCmd_t;

endpackage

// File: rtl/rail_seq_sync.sv
`timescale 1ns/1ps
module rail_seq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar bitIdx = 0; bitIdx < WIDTH; bitIdx++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], asyncIn[bitIdx]};
    end
    assign syncOut[bitIdx] = chain[STAGES-1];
  end

endmodule

// File: rtl/rail_seq_datapath.sv
`timescale 1ns/1ps
module rail_seq_datapath
  import rail_seq_pkg::*;
#(
  parameter int HOLD_CYCLES    = 125000,
  parameter int TIMEOUT_CYCLES = 500000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  seqCmd_t               cmd,
  output logic                  holdDone,
  output logic                  timeoutHit,
  output logic [RAIL_COUNT-1:0] enOut,
  output logic                  pg18Out,
  output logic                  clkPulseOut,
  output logic                  allGoodOut,
  output logic                  faultOut
);

  localparam int MAX_COUNT = (HOLD_CYCLES > TIMEOUT_CYCLES) ? HOLD_CYCLES : TIMEOUT_CYCLES;
  localparam int CNT_W     = $clog2(MAX_COUNT + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST    = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] TIMEOUT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_CEIL     = CNT_W'(MAX_COUNT);

  logic [CNT_W-1:0] stepCnt;

  // Shared step timer: cleared on each state change, saturates at its ceiling.
  always_ff @(posedge clk) begin
    if (rst)                   stepCnt <= '0;
    else if (cmd.clrTimer)     stepCnt <= '0;
    else if (stepCnt != CNT_CEIL) stepCnt <= stepCnt + 1'b1;
  end

  assign holdDone   = (stepCnt == HOLD_LAST);
  assign timeoutHit = (stepCnt == TIMEOUT_LAST);

  // Output registers. During shutdown the target only ever removes enables.
  always_ff @(posedge clk) begin
    if (rst) begin
      enOut       <= '0;
      pg18Out     <= 1'b0;
      clkPulseOut <= 1'b0;
      allGoodOut  <= 1'b0;
      faultOut    <= 1'b0;
    end else begin
      if (cmd.shutdown) begin
        enOut   <= enOut & cmd.enTarget;
        pg18Out <= pg18Out & cmd.enTarget[RAIL_V18];
      end else begin
        enOut   <= cmd.enTarget;
        pg18Out <= cmd.pg18;
      end
      clkPulseOut <= cmd.clkPulse;
      allGoodOut  <= cmd.allGood;
      faultOut    <= cmd.fault;
    end
  end

  assert_order_v10_R3: assert property (@(posedge clk) disable iff (rst)
    enOut[RAIL_V10] |-> enOut[RAIL_CORE]);
  assert_order_v18_R3: assert property (@(posedge clk) disable iff (rst)
    enOut[RAIL_V18] |-> enOut[RAIL_V10]);
  assert_order_v15_R3: assert property (@(posedge clk) disable iff (rst)
    enOut[RAIL_V15] |-> enOut[RAIL_V18]);
  assert_pg18_needs_en_R4: assert property (@(posedge clk) disable iff (rst)
    pg18Out |-> enOut[RAIL_V18]);
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
    clkPulseOut |=> !clkPulseOut);
  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    faultOut |=> faultOut);
  assert_one_release_R9: assert property (@(posedge clk) disable iff (rst)
    $countones($past(enOut) & ~enOut) <= 1);

endmodule

// File: rtl/rail_seq_ctrl.sv
`timescale 1ns/1ps
module rail_seq_ctrl
  import rail_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    startSync,
  input  logic    pgCoreSync,
  input  logic    pg10Sync,
  input  logic    pg15Sync,
  input  logic    holdDone,
  input  logic    timeoutHit,
  output seqCmd_t cmd
);

  seqState_t state, nextState;
  logic      startPrev;
  logic      startRise;
  logic      dropFault;
  logic      pulseNow;

  function automatic logic [RAIL_COUNT-1:0] railMask(seqState_t s);
    case (s)
      S_CORE_WAIT, S_CORE_HOLD:              railMask = 4'b0001;
      S_V10_WAIT, S_V10_HOLD:                railMask = 4'b0011;
      S_V18_RAMP, S_V18_STABLE:              railMask = 4'b0111;
      S_V15_WAIT, S_V15_HOLD, S_DONE:        railMask = 4'b1111;
      S_OFF15:                               railMask = 4'b0111;
      S_OFF18:                               railMask = 4'b0011;
      S_OFF10:                               railMask = 4'b0001;
      default:                               railMask = 4'b0000;
    endcase
  endfunction

  assign startRise = startSync & ~startPrev;

  // A rail already accepted as good must stay good.
  always_comb begin
    dropFault = 1'b0;
    if ((state inside {S_CORE_HOLD, S_V10_WAIT, S_V10_HOLD, S_V18_RAMP, S_V18_STABLE,
                       S_V15_WAIT, S_V15_HOLD, S_DONE}) && !pgCoreSync)
      dropFault = 1'b1;
    if ((state inside {S_V10_HOLD, S_V18_RAMP, S_V18_STABLE, S_V15_WAIT,
                       S_V15_HOLD, S_DONE}) && !pg10Sync)
      dropFault = 1'b1;
    if ((state inside {S_V15_HOLD, S_DONE}) && !pg15Sync)
      dropFault = 1'b1;
  end

  always_comb begin
    nextState = state;
    pulseNow  = 1'b0;
    case (state)
      S_IDLE:       if (startRise) nextState = S_CORE_WAIT;
      S_CORE_WAIT:  if (pgCoreSync) nextState = S_CORE_HOLD;
                    else if (timeoutHit) nextState = S_OFF15;
      S_CORE_HOLD:  if (holdDone) nextState = S_V10_WAIT;
      S_V10_WAIT:   if (pg10Sync) nextState = S_V10_HOLD;
                    else if (timeoutHit) nextState = S_OFF15;
      S_V10_HOLD:   if (holdDone) nextState = S_V18_RAMP;
      S_V18_RAMP:   if (holdDone) nextState = S_V18_STABLE;
      S_V18_STABLE: if (holdDone) begin
                      nextState = S_V15_WAIT;
                      pulseNow  = 1'b1;
                    end
      S_V15_WAIT:   if (pg15Sync) nextState = S_V15_HOLD;
                    else if (timeoutHit) nextState = S_OFF15;
      S_V15_HOLD:   if (holdDone) nextState = S_DONE;
      S_DONE:       nextState = S_DONE;
      S_OFF15:      nextState = S_OFF18;
      S_OFF18:      nextState = S_OFF10;
      S_OFF10:      nextState = S_OFFCORE;
      S_OFFCORE:    nextState = S_HALT;
      S_HALT:       nextState = S_HALT;
      default:      nextState = S_IDLE;
    endcase
    if (dropFault) begin
      nextState = S_OFF15;
      pulseNow  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      startPrev <= 1'b0;
    end else begin
      state     <= nextState;
      startPrev <= startSync;
    end
  end

  // Outputs follow the state being entered, so they change with the state.
  always_comb begin
    cmd.clrTimer = (nextState != state);
    cmd.fault    = nextState inside {S_OFF15, S_OFF18, S_OFF10, S_OFFCORE, S_HALT};
    cmd.shutdown = cmd.fault;
    cmd.enTarget = railMask(nextState);
    cmd.pg18     = nextState inside {S_V18_STABLE, S_V15_WAIT, S_V15_HOLD, S_DONE};
    cmd.clkPulse = pulseNow;
    cmd.allGood  = (nextState == S_DONE);
  end

  assert_idle_needs_start_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !startSync) |=> state == S_IDLE);
  assert_timeout_core_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_CORE_WAIT && !pgCoreSync && timeoutHit) |=> state == S_OFF15);
  assert_drop_done_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_DONE && !(pgCoreSync && pg10Sync && pg15Sync)) |=> state == S_OFF15);
  assert_halt_stays_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_HALT) |=> state == S_HALT);

endmodule

// File: rtl/rail_sequencer.sv
`timescale 1ns/1ps
module rail_sequencer
  import rail_seq_pkg::*;
#(
  parameter int HOLD_CYCLES    = 125000,
  parameter int TIMEOUT_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic startReq,
  input  logic pgCoreIn,
  input  logic pg1v0In,
  input  logic pg1v5In,
  output logic enCore,
  output logic en1v0,
  output logic en1v8,
  output logic en1v5,
  output logic pg1v8Out,
  output logic clkInitPulse,
  output logic allGood,
  output logic faultFlag
);

  logic [3:0]            syncBus;
  logic [RAIL_COUNT-1:0] enBus;
  logic                  holdDone;
  logic                  timeoutHit;
  seqCmd_t               cmd;

  rail_seq_sync #(.WIDTH(4), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn ({pg1v5In, pg1v0In, pgCoreIn, startReq}),
    .syncOut (syncBus)
  );

  rail_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .startSync  (syncBus[0]),
    .pgCoreSync (syncBus[1]),
    .pg10Sync   (syncBus[2]),
    .pg15Sync   (syncBus[3]),
    .holdDone   (holdDone),
    .timeoutHit (timeoutHit),
    .cmd        (cmd)
  );

  rail_seq_datapath #(
    .HOLD_CYCLES    (HOLD_CYCLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_datapath (
    .clk         (clk),
    .rst         (rst),
    .cmd         (cmd),
    .holdDone    (holdDone),
    .timeoutHit  (timeoutHit),
    .enOut       (enBus),
    .pg18Out     (pg1v8Out),
    .clkPulseOut (clkInitPulse),
    .allGoodOut  (allGood),
    .faultOut    (faultFlag)
  );

  assign enCore = enBus[RAIL_CORE];
  assign en1v0  = enBus[RAIL_V10];
  assign en1v8  = enBus[RAIL_V18];
  assign en1v5  = enBus[RAIL_V15];

  assert_allgood_rails_R6: assert property (@(posedge clk) disable iff (rst)
    allGood |-> (en1v5 && pg1v8Out && !faultFlag));
  assert_fault_clears_good_R8: assert property (@(posedge clk) disable iff (rst)
    faultFlag |-> !allGood);

endmodule

// File: tb/rail_sequencer_bench.sv
`timescale 1ns/1ps
module rail_sequencer_bench;

  localparam int HOLD  = 16;
  localparam int TMO   = 64;
  localparam int NEVER = -1;
  localparam int NUM_SCEN = 5;
  // Columns: core delay, 1.0 V delay, 1.5 V delay, expected all-good, expected strobes.
  localparam int SCEN [NUM_SCEN][5] = '{
    '{2,     5,     3,     1, 1},
    '{40,    1,     50,    1, 1},
    '{NEVER, 0,     0,     0, 0},
    '{3,     NEVER, 0,     0, 0},
    '{3,     3,     NEVER, 0, 1}
  };

  logic clk = 1'b0;
  logic rst, startReq, pgCoreIn, pg1v0In, pg1v5In;
  logic enCore, en1v0, en1v8, en1v5, pg1v8Out, clkInitPulse, allGood, faultFlag;
  int   passCount = 0;
  int   checkCount = 0;
  int   pulseCount = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  rail_sequencer #(.HOLD_CYCLES(HOLD), .TIMEOUT_CYCLES(TMO)) u_rail_sequencer (
    .clk(clk), .rst(rst), .startReq(startReq), .pgCoreIn(pgCoreIn),
    .pg1v0In(pg1v0In), .pg1v5In(pg1v5In), .enCore(enCore), .en1v0(en1v0),
    .en1v8(en1v8), .en1v5(en1v5), .pg1v8Out(pg1v8Out), .clkInitPulse(clkInitPulse),
    .allGood(allGood), .faultFlag(faultFlag)
  );

  always @(negedge clk) begin
    if (rst) pulseCount = 0;
    else if (clkInitPulse) pulseCount = pulseCount + 1;
  end

  task automatic check(string req, int act, int exp);
    checkCount++;
    if (act == exp) passCount++;
    else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  function automatic logic sig(int idx);
    case (idx)
      0: sig = enCore;   1: sig = en1v0;    2: sig = en1v8;        3: sig = en1v5;
      4: sig = pg1v8Out; 5: sig = clkInitPulse; 6: sig = allGood; default: sig = faultFlag;
    endcase
  endfunction

  task automatic waitSig(int idx, int limit, output int cycles);
    cycles = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      cycles++;
      if (sig(idx)) return;
    end
    cycles = -1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; startReq = 1'b0; pgCoreIn = 1'b0; pg1v0In = 1'b0; pg1v5In = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    startReq = 1'b1;
    repeat (2) @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic checkAllOff(string req);
    check(req, {enCore, en1v0, en1v8, en1v5, pg1v8Out, clkInitPulse, allGood}, 0);
  endtask

  task automatic runScenario(int row);
    int c;
    int dCore = SCEN[row][0];
    int d10   = SCEN[row][1];
    int d15   = SCEN[row][2];
    doReset();
    pulseStart();
    waitSig(0, 20, c);
    check("R2 core enable after start", (c > 0) ? 1 : 0, 1);
    if (dCore == NEVER) begin
      waitSig(7, TMO + 20, c);
      check("R7 core timeout fault", (c > 0) ? 1 : 0, 1);
    end else begin
      repeat (dCore) @(negedge clk);
      check("R3 no 1.0V enable before core good", en1v0, 0);
      pgCoreIn = 1'b1;
      waitSig(1, HOLD + 20, c);
      check("R3 core good to 1.0V enable", c, HOLD + 3);
      if (d10 == NEVER) begin
        waitSig(7, TMO + 20, c);
        check("R7 1.0V timeout fault", (c > 0) ? 1 : 0, 1);
      end else begin
        repeat (d10) @(negedge clk);
        check("R3 no 1.8V enable before 1.0V good", en1v8, 0);
        pg1v0In = 1'b1;
        waitSig(2, HOLD + 20, c);
        check("R3 1.0V good to 1.8V enable", c, HOLD + 3);
        waitSig(4, HOLD + 20, c);
        check("R4 1.8V good after hold", c, HOLD);
        waitSig(5, HOLD + 20, c);
        check("R5 clock strobe after hold", c, HOLD);
        check("R5 1.5V enable with strobe", en1v5, 1);
        @(negedge clk);
        check("R5 strobe one cycle", clkInitPulse, 0);
        if (d15 == NEVER) begin
          waitSig(7, TMO + 20, c);
          check("R7 1.5V timeout fault", (c > 0) ? 1 : 0, 1);
        end else begin
          repeat (d15) @(negedge clk);
          pg1v5In = 1'b1;
          waitSig(6, HOLD + 20, c);
          check("R6 1.5V good to all-good", c, HOLD + 3);
        end
      end
    end
    if (SCEN[row][3] == 0) begin
      repeat (6) @(negedge clk);
      check("R7 enables off after timeout", {enCore, en1v0, en1v8, en1v5}, 0);
    end
    check("R6 final all-good", allGood, SCEN[row][3]);
    check("R5 strobe count", pulseCount, SCEN[row][4]);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checkCount++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", passCount, checkCount);
      $finish;
    end
  end

  initial begin
    int c;
    rst = 1'b1; startReq = 1'b0; pgCoreIn = 1'b0; pg1v0In = 1'b0; pg1v5In = 1'b0;
    repeat (3) @(negedge clk);
    checkAllOff("R1 outputs during reset");
    check("R1 fault during reset", faultFlag, 0);
    rst = 1'b0;
    @(negedge clk);
    checkAllOff("R1 outputs after reset");

    // R2: nothing happens without a start edge, even with power-good inputs high.
    pgCoreIn = 1'b1; pg1v0In = 1'b1;
    repeat (30) @(negedge clk);
    check("R2 idle without start", enCore, 0);

    for (int row = 0; row < NUM_SCEN; row++) runScenario(row);

    // R8 and R9: drop of an accepted rail, reverse-order shutdown.
    runScenario(0);
    pg1v0In = 1'b0;
    waitSig(7, 10, c);
    check("R8 drop raises fault", (c > 0) ? 1 : 0, 1);
    check("R8 all-good falls", allGood, 0);
    check("R9 step1 1.5V off 1.8V on", {en1v5, en1v8}, 2'b01);
    @(negedge clk);
    check("R9 step2 1.8V off with good flag, 1.0V on", {en1v8, pg1v8Out, en1v0}, 3'b001);
    @(negedge clk);
    check("R9 step3 1.0V off core on", {en1v0, enCore}, 2'b01);
    @(negedge clk);
    check("R9 step4 core off", enCore, 0);
    pulseStart();
    repeat (40) @(negedge clk);
    check("R9 start ignored after fault", enCore, 0);
    check("R9 fault held", faultFlag, 1);
    doReset();
    @(negedge clk);
    check("R1 reset clears fault", faultFlag, 0);

    // R5: a new start edge after completion does not repeat the strobe.
    runScenario(0);
    pulseStart();
    repeat (3 * HOLD) @(negedge clk);
    check("R5 no second strobe", pulseCount, 1);
    check("R5 still all-good", allGood, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", passCount, checkCount);
    $finish;
  end

endmodule